// File: doc/BRIEF.md
# Reconfigurable Register-Exchange Viterbi Decoder

This block decodes a hard-decision, rate 1/2 convolutional code whose constraint length is chosen at the start of each packet as 5, 7 or 9. Each accepted input is one pair of coded bits, which is one trellis step. In that step the block evaluates branch metrics and add-compare-select for every trellis state at once. Each state carries its own survivor register, and the winning predecessor's survivor is shifted and extended with the new decision every step. No traceback pass is needed.

The state lanes are sized for the largest trellis (256 states). When a shorter code is selected, the lanes above the active trellis receive no update enable and keep their contents. Path metrics are 8-bit and are renormalised whenever the best metric reaches half scale. In the body of a packet, the block emits the oldest survivor bit of the best state once the decision depth of 5·K steps has been reached. After the last step, it flushes the remaining bits from the survivor of state 0, because the encoder is assumed to end with K-1 zero tail bits.

Top module: `vit_re_decoder`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `in_ready`, `out_valid` and `out_last` are low. The block then waits for `start`.
- R2: A `start` pulse while idle latches `k_code` (0 selects K=5, 1 selects K=7, 2 selects K=9). `in_ready` is high on the following cycle, and state 0 begins with metric 0 while every other state begins at 255.
- R3: An error-free packet is decoded exactly for each K. `in_sym[0]` carries the first generator's bit and `in_sym[1]` the second. The generators in octal are 23/35 for K=5, 171/133 for K=7 and 561/753 for K=9. The most significant tap multiplies the newest input bit. The decoded stream equals the message followed by its K-1 zero tail bits.
- R4: Isolated single-bit errors placed at least 20 steps apart are corrected, so the output still equals the message and tail bit for bit.
- R5: A packet of N steps yields exactly N output bits in step order. `out_last` is high only on the N-th bit, and is followed by a cycle without `out_valid`.
- R6: After the step flagged `in_last` is accepted, `in_ready` is low until the flush has finished.
- R7: A packet shorter than the decision depth of 5·K steps is delivered entirely by the flush, with the correct count and content.
- R8: Path metrics never overflow. The best metric stays at or below 129, and a long packet carrying more than 128 corrected errors decodes exactly.
- R9: State lanes at or above 2^(K-1) hold their metric and survivor during a packet. A K=5 packet that follows a K=9 packet decodes exactly.
- R10: A `start` pulse while a packet is in progress has no effect: the constraint length is not changed and the packet decodes exactly.
- R11: Cycles with `in_valid` low consume no step, so a packet with idle gaps decodes exactly.
- R12: `k_code` value 3 selects K=9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a packet (taken only while idle) |
| k_code | input | 2 | Constraint length select, sampled with `start` |
| in_valid | input | 1 | Coded pair present |
| in_ready | output | 1 | Block accepts a coded pair this cycle |
| in_sym | input | 2 | Received coded pair, bit 0 = first generator |
| in_last | input | 1 | Marks the final step of the packet (tail included) |
| out_valid | output | 1 | Decoded bit present |
| out_bit | output | 1 | Decoded bit, in step order |
| out_last | output | 1 | Final decoded bit of the packet |

## Verification
The embedded assertions check the following on every cycle: the metric bound after renormalisation, that disabled lanes hold their metric and survivor, the initial metrics loaded at a packet start, that input stalls once the last step is taken, that a stray `start` during a packet leaves the constraint length unchanged, and that `out_last` closes the output stream. Whether the trellis wiring, generator taps, survivor shifting and decision depth combine into correct decoding only shows up end to end. The bench encodes pseudo-random messages for each K, adds spaced bit errors and idle gaps, and compares every output bit. The short-packet flush, back-to-back reconfiguration and a reset in mid-packet are likewise covered only by bench scenarios.

// File: rtl/vit_pkg.sv
`timescale 1ns/1ps
// vit_pkg: shared constants, state type and code definitions for the
// register-exchange Viterbi decoder. Assumes the code family is fixed to
// constraint lengths 5, 7 and 9 at rate 1/2.
package vit_pkg;

    localparam int K_MAX = 9;
    localparam int M_MAX = K_MAX - 1;
    localparam int N_ST  = 1 << M_MAX;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FLUSH} dec_state_e;

    // Constraint length encoded by a k_code value (3 behaves as 9).
    function automatic int k_len(input logic [1:0] kc);
        case (kc)
            2'd0:    return 5;
            2'd1:    return 7;
            default: return 9;
        endcase
    endfunction

    // Rank 0..2 of the selected trellis size.
    function automatic logic [1:0] k_rank(input logic [1:0] kc);
        return (kc == 2'd3) ? 2'd2 : kc;
    endfunction

    // Generator polynomial; bit K-1 taps the newest input.
    function automatic logic [K_MAX-1:0] gen_poly(input logic [1:0] kc, input logic sel);
        case (k_rank(kc))
            2'd0:    return sel ? 9'o035 : 9'o023;
            2'd1:    return sel ? 9'o133 : 9'o171;
            default: return sel ? 9'o753 : 9'o561;
        endcase
    endfunction

    // Encoder output for window w, where w[d] is the input d steps old.
    function automatic logic enc_bit(input logic [1:0] kc, input logic sel,
                                     input logic [K_MAX-1:0] w);
        logic [K_MAX-1:0] g;
        int               k;
        logic             p;
        g = gen_poly(kc, sel);
        k = k_len(kc);
        p = 1'b0;
        for (int d = 0; d < K_MAX; d++) begin
            if (d < k) p = p ^ (w[d] & g[k-1-d]);
        end
        return p;
    endfunction

endpackage

// File: rtl/vit_min_tree.sv
`timescale 1ns/1ps
// vit_min_tree: finds the smallest enabled path metric and its lane index.
// Disabled lanes count as the largest value; ties resolve to the lower index.
// Assumes N is a power of two.
module vit_min_tree #(
    parameter int N  = 256,
    parameter int W  = 8,
    parameter int IW = 8
) (
    input  logic [W-1:0]  vals [N],
    input  logic [N-1:0]  act,
    output logic [W-1:0]  min_v,
    output logic [IW-1:0] min_i
);

    logic [W-1:0]  v  [N];
    logic [IW-1:0] ix [N];

    // Pairwise reduction with doubling stride.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            v[i]  = act[i] ? vals[i] : '1;
            ix[i] = IW'(i);
        end
        for (int s = 1; s < N; s = s * 2) begin
            for (int i = 0; i < N; i = i + 2 * s) begin
                if (v[i+s] < v[i]) begin
                    v[i]  = v[i+s];
                    ix[i] = ix[i+s];
                end
            end
        end
    end

    assign min_v = v[0];
    assign min_i = ix[0];

endmodule

// File: rtl/vit_acs_lane.sv
`timescale 1ns/1ps
// vit_acs_lane: one trellis state. Computes Hamming branch metrics for its
// two predecessors, adds them with saturation after subtracting the shared
// normalisation amount, keeps the smaller sum and updates its survivor by
// register exchange. Holds its contents whenever en and init are low.
module vit_acs_lane
    import vit_pkg::*;
#(
    parameter int LANE = 0,
    parameter int PM_W = 8,
    parameter int SV_W = 45
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init,
    input  logic            en,
    input  logic [1:0]      kc,
    input  logic [1:0]      sym,
    input  logic [PM_W-1:0] norm,
    input  logic [PM_W-1:0] pm_a,
    input  logic [PM_W-1:0] pm_b,
    input  logic [SV_W-1:0] sv_a,
    input  logic [SV_W-1:0] sv_b,
    output logic [PM_W-1:0] pm_q,
    output logic [SV_W-1:0] sv_q
);

    localparam logic [PM_W-1:0] PM_MAX  = '1;
    localparam logic [PM_W-1:0] INIT_PM = (LANE == 0) ? '0 : PM_MAX;
    localparam logic            DEC_BIT = 1'(LANE % 2);

    logic [K_MAX-1:0] w_a, w_b;
    logic [1:0]       bm_a, bm_b;
    logic [PM_W-1:0]  cand_a, cand_b;
    logic             pick_b;
    logic [SV_W-1:0]  sv_sel;

    function automatic logic [PM_W-1:0] sat_add(input logic [PM_W-1:0] base,
                                                input logic [1:0] bm);
        logic [PM_W:0] s;
        s = {1'b0, base} + (PM_W+1)'(bm);
        return s[PM_W] ? PM_MAX : s[PM_W-1:0];
    endfunction

    // Branch metrics and compare-select for the two incoming branches.
    always_comb begin
        w_a    = K_MAX'(LANE);
        w_b    = w_a | (K_MAX'(1) << (k_len(kc) - 1));
        bm_a   = {1'b0, enc_bit(kc, 1'b0, w_a) ^ sym[0]} + {1'b0, enc_bit(kc, 1'b1, w_a) ^ sym[1]};
        bm_b   = {1'b0, enc_bit(kc, 1'b0, w_b) ^ sym[0]} + {1'b0, enc_bit(kc, 1'b1, w_b) ^ sym[1]};
        cand_a = sat_add(pm_a - norm, bm_a);
        cand_b = sat_add(pm_b - norm, bm_b);
        pick_b = cand_b < cand_a;
        sv_sel = pick_b ? sv_b : sv_a;
    end

    // State registers: reset, packet initialisation or gated update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_q <= '0;
            sv_q <= '0;
        end else if (init) begin
            pm_q <= INIT_PM;
            sv_q <= '0;
        end else if (en) begin
            pm_q <= pick_b ? cand_b : cand_a;
            sv_q <= SV_W'({sv_sel, DEC_BIT});
        end
    end

    a_r9_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !init) |=> ($stable(pm_q) && $stable(sv_q)));

    a_r2_init_metric: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (pm_q == INIT_PM));

endmodule

// File: rtl/vit_re_decoder.sv
`timescale 1ns/1ps
// vit_re_decoder: hard-decision rate 1/2 Viterbi decoder, K = 5/7/9 chosen
// per packet. One trellis step per accepted input pair, all states in
// parallel, survivors by register exchange. Lanes outside the selected
// trellis are clock-enable gated. Assumes the encoder ends in state 0.
module vit_re_decoder
    import vit_pkg::*;
#(
    parameter int PM_W      = 8,
    parameter int DEPTH_MUL = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] k_code,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [1:0] in_sym,
    input  logic       in_last,
    output logic       out_valid,
    output logic       out_bit,
    output logic       out_last
);

    localparam int SV_W  = DEPTH_MUL * K_MAX;
    localparam int IDX_W = $clog2(SV_W);
    localparam int CNT_W = $clog2(SV_W + 1) + 1;
    localparam int HALF  = 1 << (PM_W - 1);

    dec_state_e        st_q;
    logic [1:0]        kc_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  fidx_q;
    logic              ov_q, ob_q, ol_q;

    logic [PM_W-1:0]   pm [N_ST];
    logic [SV_W-1:0]   sv [N_ST];
    logic [N_ST-1:0]   lane_act;
    logic [PM_W-1:0]   best_pm, norm;
    logic [M_MAX-1:0]  best_ix;
    logic [IDX_W-1:0]  depth_m1;
    logic              acc, init;

    // Handshake, packet start and per-K decision depth.
    always_comb begin
        in_ready = (st_q == ST_RUN);
        acc      = in_valid && in_ready;
        init     = start && (st_q == ST_IDLE);
        depth_m1 = IDX_W'(DEPTH_MUL * k_len(kc_q) - 1);
        norm     = (best_pm >= PM_W'(HALF)) ? best_pm : '0;
    end

    // One lane per state; sources follow next = (prev << 1 | bit).
    for (genvar j = 0; j < N_ST; j++) begin : g_lane
        localparam int NEED = (j < (1 << (k_len(2'd0) - 1))) ? 0 :
                              (j < (1 << (k_len(2'd1) - 1))) ? 1 : 2;
        localparam int PA   = j >> 1;
        localparam int PB0  = PA | (1 << (k_len(2'd0) - 2));
        localparam int PB1  = PA | (1 << (k_len(2'd1) - 2));
        localparam int PB2  = PA | (1 << (k_len(2'd2) - 2));

        logic [PM_W-1:0] pm_b;
        logic [SV_W-1:0] sv_b;

        // Upper predecessor depends on the trellis half-size.
        always_comb begin
            case (k_rank(kc_q))
                2'd0:    begin pm_b = pm[PB0]; sv_b = sv[PB0]; end
                2'd1:    begin pm_b = pm[PB1]; sv_b = sv[PB1]; end
                default: begin pm_b = pm[PB2]; sv_b = sv[PB2]; end
            endcase
        end

        assign lane_act[j] = (k_rank(kc_q) >= 2'(NEED));

        vit_acs_lane #(.LANE(j), .PM_W(PM_W), .SV_W(SV_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .init  (init),
            .en    (acc && lane_act[j]),
            .kc    (kc_q),
            .sym   (in_sym),
            .norm  (norm),
            .pm_a  (pm[PA]),
            .pm_b  (pm_b),
            .sv_a  (sv[PA]),
            .sv_b  (sv_b),
            .pm_q  (pm[j]),
            .sv_q  (sv[j])
        );
    end

    vit_min_tree #(.N(N_ST), .W(PM_W), .IW(M_MAX)) u_min (
        .vals  (pm),
        .act   (lane_act),
        .min_v (best_pm),
        .min_i (best_ix)
    );

    // Packet sequencing, body output and end-of-packet flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            kc_q   <= 2'd0;
            cnt_q  <= '0;
            fidx_q <= '0;
            ov_q   <= 1'b0;
            ob_q   <= 1'b0;
            ol_q   <= 1'b0;
        end else begin
            ov_q <= 1'b0;
            ol_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q  <= ST_RUN;
                        kc_q  <= k_code;
                        cnt_q <= '0;
                    end
                end
                ST_RUN: begin
                    if (acc) begin
                        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
                        if (cnt_q > CNT_W'(depth_m1)) begin
                            ov_q <= 1'b1;
                            ob_q <= sv[best_ix][depth_m1];
                        end
                        if (in_last) begin
                            st_q   <= ST_FLUSH;
                            fidx_q <= (cnt_q >= CNT_W'(depth_m1)) ? depth_m1 : IDX_W'(cnt_q);
                        end
                    end
                end
                default: begin
                    ov_q <= 1'b1;
                    ob_q <= sv[0][fidx_q];
                    if (fidx_q == '0) begin
                        ol_q <= 1'b1;
                        st_q <= ST_IDLE;
                    end else begin
                        fidx_q <= fidx_q - 1'b1;
                    end
                end
            endcase
        end
    end

    assign out_valid = ov_q;
    assign out_bit   = ob_q;
    assign out_last  = ol_q;

    a_r8_metric_bound: assert property (@(posedge clk) disable iff (!rst_n)
        best_pm <= PM_W'(HALF + 1));

    a_r6_stall_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_last) |=> !in_ready);

    a_r5_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    a_r5_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> (!out_valid && !out_last));

    a_r10_start_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (start && st_q != ST_IDLE) |=> (kc_q == $past(kc_q)));

endmodule

// File: tb/tb_vit_re_decoder.sv
`timescale 1ns/1ps
// Bench: encodes pseudo-random packets, injects spaced errors and gaps,
// and compares the decoded stream bit for bit.
module tb_vit_re_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] k_code = 2'd0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] in_sym = 2'd0;
    logic       in_last = 1'b0;
    logic       out_valid, out_bit, out_last;

    always #2.5 clk = ~clk;

    vit_re_decoder dut (
        .clk(clk), .rst_n(rst_n), .start(start), .k_code(k_code),
        .in_valid(in_valid), .in_ready(in_ready), .in_sym(in_sym),
        .in_last(in_last), .out_valid(out_valid), .out_bit(out_bit),
        .out_last(out_last)
    );

    // Packet table: k_code, message length, error spacing (0 = none), gaps, requirement.
    localparam int NPK = 9;
    localparam int TBL [NPK][5] = '{
        '{0,   60,  0, 0,  3},   // R3 K=5 clean
        '{1,   80,  0, 0,  3},   // R3 K=7 clean
        '{2,  100,  0, 1, 11},   // R11 K=9 with idle gaps
        '{0,  120, 25, 0,  4},   // R4 K=5 with errors
        '{1,  150, 25, 0,  4},   // R4 K=7 with errors
        '{2,  150, 20, 1,  4},   // R4 K=9 with errors and gaps
        '{3,   70, 30, 0, 12},   // R12 code 3 runs K=9
        '{0,   40,  0, 0,  9},   // R9 K=5 right after K=9
        '{2, 1500, 10, 0,  8}    // R8 over 128 corrected errors
    };

    int          total = 0, bad = 0;
    int          got_n = 0, last_cnt = 0, last_pos = -1;
    int          cyc = 0;
    int unsigned rs = 32'h1ACE_2B07;
    bit          msg  [2048];
    bit [1:0]    code [2048];
    bit          got  [2048];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit rnd_bit();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs[7];
    endfunction

    function automatic bit enc(input int k, input int sel, input bit [8:0] w);
        bit [8:0] g;
        bit       p = 0;
        case (k)
            5:       g = sel ? 9'o035 : 9'o023;
            7:       g = sel ? 9'o133 : 9'o171;
            default: g = sel ? 9'o753 : 9'o561;
        endcase
        for (int d = 0; d < k; d++) p = p ^ (w[d] & g[k-1-d]);
        return p;
    endfunction

    // Output collector, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (got_n < 2048) got[got_n] = out_bit;
            if (out_last) begin
                last_cnt++;
                last_pos = got_n;
            end
            got_n++;
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL R5 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_packet(input int kc, input int len, input int spacing,
                              input bit gap, input bit mid, input string tag);
        int       k = (kc == 0) ? 5 : (kc == 1) ? 7 : 9;
        int       n = len + k - 1;
        bit [8:0] w = '0;
        bit [8:0] mask = 9'((1 << k) - 1);
        int       i = 0, c = 0, errs = 0;
        bit       pulsed = 0;
        for (int s = 0; s < n; s++) begin
            bit b = (s < len) ? rnd_bit() : 1'b0;
            bit [1:0] sy;
            msg[s] = b;
            w = ((w << 1) | 9'(b)) & mask;
            sy = {enc(k, 1, w), enc(k, 0, w)};
            if (spacing > 0 && (s % spacing) == spacing / 2) sy[(s / spacing) % 2] ^= 1'b1;
            code[s] = sy;
        end
        got_n = 0; last_cnt = 0; last_pos = -1;
        @(negedge clk); start = 1'b1; k_code = 2'(kc);
        @(negedge clk); start = 1'b0;
        check(in_ready == 1'b1, "R2", int'(in_ready), 1);
        while (i < n) begin
            @(negedge clk);
            c++;
            start = 1'b0;
            if (mid && i == 5 && !pulsed) begin
                start = 1'b1; k_code = 2'd2; pulsed = 1;
            end
            if (gap && (c % 3) == 0) begin
                in_valid = 1'b0;
            end else begin
                in_valid = 1'b1;
                in_sym   = code[i];
                in_last  = (i == n - 1);
                if (in_ready) i++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; start = 1'b0;
        check(in_ready == 1'b0, "R6", int'(in_ready), 0);
        while (last_cnt == 0) @(posedge clk);
        repeat (2) @(negedge clk);
        check(got_n == n, "R5 count", got_n, n);
        for (int s = 0; s < n && s < got_n; s++) if (got[s] != msg[s]) errs++;
        check(errs == 0, tag, errs, 0);
        check(last_cnt == 1 && last_pos == n - 1, "R5 last", last_pos, n - 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(in_ready == 1'b0 && out_valid == 1'b0 && out_last == 1'b0, "R1", int'(in_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b0 && out_valid == 1'b0, "R1", int'(in_ready), 0);

        for (int e = 0; e < NPK; e++) begin
            run_packet(TBL[e][0], TBL[e][1], TBL[e][2], TBL[e][3] != 0, 1'b0,
                       $sformatf("R%0d", TBL[e][4]));
        end

        // R7: packet shorter than the decision depth.
        run_packet(1, 10, 0, 1'b0, 1'b0, "R7");
        // R10: stray start with another k_code in mid-packet.
        run_packet(0, 50, 0, 1'b0, 1'b1, "R10");

        // R1: reset in mid-packet returns to idle with outputs quiet.
        @(negedge clk); start = 1'b1; k_code = 2'd1;
        @(negedge clk); start = 1'b0;
        for (int s = 0; s < 45; s++) begin
            @(negedge clk); in_valid = 1'b1; in_sym = 2'(s % 4);
        end
        @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b0 && out_valid == 1'b0, "R1 mid-reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b0, "R1 idle", int'(in_ready), 0);
        run_packet(1, 60, 30, 1'b0, 1'b0, "R1 after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule